// File: doc/BRIEF.md
# Dual-Line Queue Event Interrupt Controller

This block turns per-queue status flags into two interrupt lines. There are 64 queues in two halves of 32. Each queue in the lower half has its own 3-bit source code. The code picks one of the queue's four status flags and can invert it. Every queue in the upper half watches a single fixed condition, its not-nearly-empty flag. The flags themselves come from outside the block as plain inputs.

Each half has an enable word and a sticky pending word. A pending bit is set when its queue's selected condition goes from low to high while the queue is enabled. It stays set until software writes a 1 to it. Each half's interrupt line is high while any of its pending bits is set.

Software reaches the controller through a single-cycle write port and a combinational read port. Both use eight word addresses:

| Address | Contents |
|---|---|
| 0 to 3 | Lower-half source-code words |
| 4 | Lower enable word |
| 5 | Upper enable word |
| 6 | Lower pending word |
| 7 | Upper pending word |

Top module: `qirq_ctrl`

## Requirements
- R1: A synchronous reset sets every source code, both enable words and both pending words to zero. It also drops both interrupt lines, so every read address returns 0 after reset.
- R2: Source word w (address w, 0 to 3) serves lower queues 8w to 8w+7. Queue 8w+k keeps its code in bits [4k+2:4k]. Bit 4k+3 is reserved: writes to it are ignored and it reads back as 0, so writing all ones reads back 0x77777777.
- R3: For a lower queue q, code bits [1:0] choose flag lo_flags[4q+n], where n is the value of those two bits. Code bit 2 set inverts the chosen flag.
- R4: A lower pending bit is set when the selected condition is low at one rising clock edge and high at the next, while the queue's enable bit is 1. The pending bit reads 1 right after that second edge.
- R5: A condition rise while the enable bit is 0 sets nothing. Turning the enable on while the condition is already high also sets nothing; only a later rise does.
- R6: The condition for upper queue 32+i is hi_nne[i]. It is set by a rise of hi_nne[i] under the same rule as R4 and R5.
- R7: The lower enable word is at address 4 and the upper enable word at address 5. Both read back as written.
- R8: The lower pending word is at address 6 and the upper at address 7. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a clear and a new rise hit the same bit on the same edge, the bit stays set.
- R9: irq_lo is high exactly while a lower pending bit is set, and irq_hi likewise for the upper half. Neither half affects the other's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_flags | input | 128 | Four status flags per lower queue, queue q at bits [4q+3:4q] |
| hi_nne | input | 32 | Not-nearly-empty flag per upper queue |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for rd_addr |
| irq_lo | output | 1 | Lower-half interrupt |
| irq_hi | output | 1 | Upper-half interrupt |

## Verification
The bench goes after the following corner cases, each of which a broken design would get wrong in a visible way:

- **Level instead of edge.** The bench enables a queue whose condition is already high. A design that reacts to levels would raise an interrupt that must not appear.
- **Inverted code.** The bench uses an inverted source code whose condition rises when the flag falls. A design that ignored the invert bit would fire on the wrong transition.
- **Reserved bit.** Source words are written with all ones. A design that stored the reserved bit would read back 0xFFFFFFFF instead of 0x77777777.
- **Clear and rise together.** The bench clears a pending bit on the same edge as a new rise on that bit. A design that lets the clear win would lose that event.
- **Half separation and boundaries.** Queue 31 and the upper half are driven while the other half is idle. Wrong indexing or wrong line wiring would show up on the wrong pending bit or the wrong line.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int NIBBLE      = 4;
    localparam int CODE_W      = 3;
    localparam int FLAGS_PER_Q = 4;

    typedef struct packed {
        logic       invert;
        logic [1:0] pick;
    } src_code_t;

    typedef enum logic [1:0] {
        CTL_EN_LO   = 2'd0,
        CTL_EN_HI   = 2'd1,
        CTL_PEND_LO = 2'd2,
        CTL_PEND_HI = 2'd3
    } ctl_reg_e;

    function automatic logic eval_code(input logic [FLAGS_PER_Q-1:0] flags,
                                       input src_code_t code);
        return flags[code.pick] ^ code.invert;
    endfunction

    function automatic src_code_t nib_to_code(input logic [NIBBLE-1:0] nib);
        return src_code_t'(nib[CODE_W-1:0]);
    endfunction

endpackage

// File: rtl/qirq_cfg_regs.sv
module qirq_cfg_regs
    import qirq_pkg::*;
#(
    parameter int HALF_Q    = 32,
    parameter int ADDR_W    = 3,
    parameter int SRC_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [HALF_Q-1:0]        wr_data,
    output logic [HALF_Q*CODE_W-1:0] codes_o,
    output logic [HALF_Q-1:0]        en_lo_o,
    output logic [HALF_Q-1:0]        en_hi_o
);
    localparam int QPW = HALF_Q / SRC_WORDS;
    localparam logic [ADDR_W-1:0] A_EN_LO = ADDR_W'(SRC_WORDS + int'(CTL_EN_LO));
    localparam logic [ADDR_W-1:0] A_EN_HI = ADDR_W'(SRC_WORDS + int'(CTL_EN_HI));

    for (genvar q = 0; q < HALF_Q; q++) begin : g_code
        localparam int W = q / QPW;
        localparam int K = q % QPW;
        src_code_t code_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                code_r <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(W)) begin
                code_r <= nib_to_code(wr_data[K*NIBBLE +: NIBBLE]);
            end
        end
        assign codes_o[q*CODE_W +: CODE_W] = code_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lo_o <= '0;
            en_hi_o <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EN_LO) en_lo_o <= wr_data;
            if (wr_addr == A_EN_HI) en_hi_o <= wr_data;
        end
    end

endmodule

// File: rtl/qirq_lo_cond.sv
module qirq_lo_cond
    import qirq_pkg::*;
#(
    parameter int HALF_Q = 32
) (
    input  logic [HALF_Q*FLAGS_PER_Q-1:0] flags_i,
    input  logic [HALF_Q*CODE_W-1:0]      codes_i,
    output logic [HALF_Q-1:0]             cond_o
);
    for (genvar q = 0; q < HALF_Q; q++) begin : g_sel
        assign cond_o[q] = eval_code(flags_i[q*FLAGS_PER_Q +: FLAGS_PER_Q],
                                     src_code_t'(codes_i[q*CODE_W +: CODE_W]));
    end
endmodule

// File: rtl/qirq_pend_unit.sv
module qirq_pend_unit #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] en_i,
    input  logic         clr_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] keep;

    assign rise = cond_i & ~prev_q & en_i;
    assign keep = clr_i ? ~clr_mask_i : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_o <= '0;
        end else begin
            prev_q <= cond_i;
            pend_o <= (pend_o & keep) | rise;
        end
    end
endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter  int HALF_Q    = 32,
    localparam int SRC_WORDS = NIBBLE,
    localparam int ADDR_W    = $clog2(SRC_WORDS + 4)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [HALF_Q*FLAGS_PER_Q-1:0] lo_flags,
    input  logic [HALF_Q-1:0]             hi_nne,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [HALF_Q-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [HALF_Q-1:0]             rd_data,
    output logic                          irq_lo,
    output logic                          irq_hi
);
    localparam int QPW = HALF_Q / SRC_WORDS;
    localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(SRC_WORDS + int'(CTL_EN_LO));
    localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(SRC_WORDS + int'(CTL_EN_HI));
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(SRC_WORDS + int'(CTL_PEND_LO));
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(SRC_WORDS + int'(CTL_PEND_HI));

    logic [HALF_Q*CODE_W-1:0] codes;
    logic [HALF_Q-1:0]        en_lo, en_hi;
    logic [HALF_Q-1:0]        cond_lo;
    logic [HALF_Q-1:0]        pend_lo, pend_hi;

    qirq_cfg_regs #(.HALF_Q(HALF_Q), .ADDR_W(ADDR_W), .SRC_WORDS(SRC_WORDS)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .codes_o(codes), .en_lo_o(en_lo), .en_hi_o(en_hi)
    );

    qirq_lo_cond #(.HALF_Q(HALF_Q)) u_cond (
        .flags_i(lo_flags), .codes_i(codes), .cond_o(cond_lo)
    );

    qirq_pend_unit #(.N(HALF_Q)) u_pend_lo (
        .clk(clk), .rst(rst), .cond_i(cond_lo), .en_i(en_lo),
        .clr_i(wr_en && wr_addr == A_PEND_LO), .clr_mask_i(wr_data), .pend_o(pend_lo)
    );

    qirq_pend_unit #(.N(HALF_Q)) u_pend_hi (
        .clk(clk), .rst(rst), .cond_i(hi_nne), .en_i(en_hi),
        .clr_i(wr_en && wr_addr == A_PEND_HI), .clr_mask_i(wr_data), .pend_o(pend_hi)
    );

    assign irq_lo = |pend_lo;
    assign irq_hi = |pend_hi;

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < SRC_WORDS) begin
            for (int k = 0; k < QPW; k++) begin
                rd_data[k*NIBBLE +: CODE_W] = codes[(int'(rd_addr)*QPW + k)*CODE_W +: CODE_W];
            end
        end else begin
            case (rd_addr)
                A_EN_LO:   rd_data = en_lo;
                A_EN_HI:   rd_data = en_hi;
                A_PEND_LO: rd_data = pend_lo;
                A_PEND_HI: rd_data = pend_hi;
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/qirq_ctrl_chk.sv
module qirq_ctrl_chk #(
    parameter int HALF_Q    = 32,
    parameter int ADDR_W    = 3,
    parameter int SRC_WORDS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [HALF_Q-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [HALF_Q-1:0] rd_data,
    input logic [HALF_Q-1:0] hi_nne,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [HALF_Q-1:0] en_lo,
    input logic [HALF_Q-1:0] en_hi,
    input logic [HALF_Q-1:0] pend_lo,
    input logic [HALF_Q-1:0] pend_hi
);
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(SRC_WORDS + 2);
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(SRC_WORDS + 3);

    logic [HALF_Q-1:0] rsv_mask;
    always_comb begin
        rsv_mask = '0;
        for (int b = 3; b < HALF_Q; b += 4) rsv_mask[b] = 1'b1;
    end

    // R5: a pending bit only appears where the enable was set
    p_set_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_lo & ~$past(pend_lo) & ~$past(en_lo)) == '0);

    // R6: an upper pending bit needs the flag high and the enable set
    p_hi_needs_nne_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_hi & ~$past(pend_hi) & ~($past(hi_nne) & $past(en_hi))) == '0);

    // R8: a bit that survives a clear must have been set again
    p_clear_survivor_r8: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == A_PEND_HI) |->
            (pend_hi & $past(wr_data) & ~$past(en_hi)) == '0);

    // R9: the lower line holds until a clear write
    p_irq_lo_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && !(wr_en && wr_addr == A_PEND_LO)) |=> irq_lo);

    // R9: the upper line holds until a clear write
    p_irq_hi_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_hi && !(wr_en && wr_addr == A_PEND_HI)) |=> irq_hi);

    // R2: reserved source bits read as zero
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) < SRC_WORDS) |-> (rd_data & rsv_mask) == '0);

endmodule

bind qirq_ctrl qirq_ctrl_chk #(.HALF_Q(HALF_Q), .ADDR_W(ADDR_W), .SRC_WORDS(SRC_WORDS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hi_nne(hi_nne), .irq_lo(irq_lo),
    .irq_hi(irq_hi), .en_lo(en_lo), .en_hi(en_hi), .pend_lo(pend_lo), .pend_hi(pend_hi)
);

// File: tb/qirq_ctrl_tb.sv
module qirq_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] lo_flags;
    logic [31:0]  hi_nne;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [31:0]  wr_data;
    logic [2:0]   rd_addr;
    logic [31:0]  rd_data;
    logic         irq_lo, irq_hi;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    qirq_ctrl dut_i (
        .clk(clk), .rst(rst), .lo_flags(lo_flags), .hi_nne(hi_nne),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // behavioural reference model
    logic [2:0]  m_src [32];
    logic [31:0] m_en_lo, m_en_hi, m_pl, m_ph, m_prev_lo, m_prev_hi;

    always @(posedge clk) begin : model
        logic [31:0] c_lo, clr_lo, clr_hi;
        if (rst) begin
            for (int q = 0; q < 32; q++) m_src[q] = 3'd0;
            m_en_lo = 0; m_en_hi = 0; m_pl = 0; m_ph = 0;
            m_prev_lo = 0; m_prev_hi = 0;
        end else begin
            for (int q = 0; q < 32; q++)
                c_lo[q] = lo_flags[q*4 + int'(m_src[q][1:0])] ^ m_src[q][2];
            clr_lo = (wr_en && wr_addr == 3'd6) ? wr_data : 32'd0;
            clr_hi = (wr_en && wr_addr == 3'd7) ? wr_data : 32'd0;
            m_pl = (m_pl & ~clr_lo) | (c_lo & ~m_prev_lo & m_en_lo);
            m_ph = (m_ph & ~clr_hi) | (hi_nne & ~m_prev_hi & m_en_hi);
            m_prev_lo = c_lo;
            m_prev_hi = hi_nne;
            if (wr_en) begin
                if (wr_addr < 3'd4)
                    for (int k = 0; k < 8; k++) m_src[int'(wr_addr)*8 + k] = wr_data[k*4 +: 3];
                else if (wr_addr == 3'd4) m_en_lo = wr_data;
                else if (wr_addr == 3'd5) m_en_hi = wr_data;
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] v = 0;
        case (a)
            3'd4: v = m_en_lo;
            3'd5: v = m_en_hi;
            3'd6: v = m_pl;
            3'd7: v = m_ph;
            default: for (int k = 0; k < 8; k++) v[k*4 +: 3] = m_src[int'(a)*8 + k];
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        chk("R9 irq_lo vs model", {31'd0, irq_lo}, {31'd0, |m_pl});
        chk("R9 irq_hi vs model", {31'd0, irq_hi}, {31'd0, |m_ph});
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp_rd(a));
    endtask

    task automatic rdl(input logic [2:0] a, input logic [31:0] lit, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, lit);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; lo_flags = {4{32'h3333_3333}}; hi_nne = '1;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        for (int a = 0; a < 8; a++) rdl(3'(a), 32'd0, "R1 reset read");
        chk("R1 irq low", {30'd0, irq_lo, irq_hi}, 32'd0);

        // R2 source map and reserved bit
        wr(3'd0, 32'hFFFF_FFFF);
        rdl(3'd0, 32'h7777_7777, "R2 reserved bits dropped");
        wr(3'd0, 32'h8888_8888);
        rdl(3'd0, 32'h0000_0000, "R2 reserved-only write");
        wr(3'd0, 32'h0000_2000);   // queue 3: pick 2
        wr(3'd1, 32'h0000_0500);   // queue 10: invert, pick 1
        wr(3'd3, 32'h3000_0000);   // queue 31: pick 3
        rd(3'd0, "R2 word0"); rd(3'd1, "R2 word1"); rd(3'd3, "R2 word3");
        rdl(3'd1, 32'h0000_0500, "R2 word1 literal");

        // R7 enables
        wr(3'd4, 32'h8000_0408);
        rdl(3'd4, 32'h8000_0408, "R7 lower enable");

        // R3 R4 pick a flag, rising edge
        lo_flags[3*4+2] = 1'b1;
        tick();
        rdl(3'd6, 32'h0000_0008, "R4 pending on rise");
        chk("R9 irq_lo raised", {31'd0, irq_lo}, 32'd1);
        wr(3'd6, 32'h0000_0008);
        rdl(3'd6, 32'h0, "R8 cleared");
        chk("R9 irq_lo dropped", {31'd0, irq_lo}, 32'd0);

        // R3 inversion: flag falls -> condition rises
        lo_flags[10*4+1] = 1'b0;
        tick();
        rdl(3'd6, 32'h0000_0400, "R3 inverted pick");

        // boundary queue 31, pick 3
        lo_flags[31*4+3] = 1'b1;
        tick();
        rdl(3'd6, 32'h8000_0400, "R3 queue 31 pick 3");

        // R8 write of zeros leaves bits alone
        wr(3'd6, 32'h0);
        rdl(3'd6, 32'h8000_0400, "R8 zero write ignored");
        wr(3'd6, 32'h8000_0400);
        rdl(3'd6, 32'h0, "R8 clear both");

        // R5 disabled queue 0 sees edges, no pending
        lo_flags[0] = 1'b0; tick();
        lo_flags[0] = 1'b1; tick();
        rdl(3'd6, 32'h0, "R5 disabled edge ignored");
        wr(3'd4, 32'h8000_0409);
        tick(); tick();
        rdl(3'd6, 32'h0, "R5 enable on high level");
        lo_flags[0] = 1'b0; tick();
        lo_flags[0] = 1'b1; tick();
        rdl(3'd6, 32'h0000_0001, "R5 later rise counts");

        // R8 clear and rise on the same edge
        lo_flags[3*4+2] = 1'b0; tick();
        lo_flags[3*4+2] = 1'b1;
        wr(3'd6, 32'h0000_0009);
        rdl(3'd6, 32'h0000_0008, "R8 set beats clear");

        // R6 upper half
        wr(3'd5, 32'h0000_0020);
        rdl(3'd5, 32'h0000_0020, "R7 upper enable");
        hi_nne[5] = 1'b0; tick();
        chk("R6 no irq on fall", {31'd0, irq_hi}, 32'd0);
        hi_nne[5] = 1'b1; tick();
        rdl(3'd7, 32'h0000_0020, "R6 upper pending");
        chk("R6 irq_hi", {31'd0, irq_hi}, 32'd1);
        wr(3'd6, 32'hFFFF_FFFF);
        chk("R9 halves independent", {30'd0, irq_lo, irq_hi}, 32'd1);
        hi_nne[6] = 1'b0; tick();
        hi_nne[6] = 1'b1; tick();
        rdl(3'd7, 32'h0000_0020, "R6 disabled upper ignored");
        wr(3'd7, 32'h0000_0020);
        rdl(3'd7, 32'h0, "R8 upper clear");
        chk("R9 irq_hi dropped", {31'd0, irq_hi}, 32'd0);

        // R1 reset in mid-run
        hi_nne[5] = 1'b0; tick();
        hi_nne[5] = 1'b1; tick();
        rst = 1; tick(); tick();
        rst = 0; tick();
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset again");
        for (int a = 0; a < 8; a++) rdl(3'(a), 32'd0, "R1 reset literal");

        finish_run();
    end
endmodule